// File: doc/BRIEF.md
# Register-to-Predicate Move Unit

This block executes a GPU-style move from a 32-bit general register into one-bit condition state. It keeps seven predicate bits and four condition flags as clocked state. When an instruction is issued, one 8-bit lane of the source value is chosen by a lane selector in the instruction word. The bits of that lane are then copied, one per target, into either the predicate file or the flag set. A per-target mask decides which targets are written and which keep their old value.

The mask arrives already resolved. It may have come from a register, a constant or an immediate, and the update rules are the same in every case. The instruction word is decoded only for the three fields this operation needs. The register index field is passed out so that the surrounding datapath can read the source operand. The stored predicates and flags are visible at all times on two output vectors.

Top module: `rpmove_unit`

## Requirements
- R1: A synchronous active-high `rst` clears all seven predicates and all four flags to 0 at the next rising edge.
- R2: While `issue` is low, a rising edge changes neither `pred_q` nor `flag_q`, whatever the other inputs are.
- R3: With `issue` high and instruction bit 40 equal to 0 (predicate mode), predicate i (i = 0..6) takes source bit (lane offset + i) at the rising edge when mask bit i is 1. A written target becomes 1 when that source bit is 1 and 0 otherwise.
- R4: The lane offset is 8 times the 2-bit lane selector in instruction bits [42:41]. Selector 3 therefore reads source bits [31:24] and selector 0 reads bits [7:0].
- R5: With `issue` high and instruction bit 40 equal to 1 (flag mode), flag index i (i = 0..3) takes source bit (lane offset + i) when mask bit i is 1. The indices map as 0 = Z, 1 = S, 2 = C and 3 = O, and `flag_q` is ordered {O, C, S, Z} from bit 3 down to bit 0.
- R6: A target whose mask bit is 0 keeps its previous value through an issued update.
- R7: Mask bits 7 to 31 have no effect in predicate mode, and mask bits 4 to 31 have no effect in flag mode. Source bits outside the selected lane, and source bits at lane positions beyond the target count, have no effect.
- R8: An issued update in one mode leaves the state of the other mode unchanged.
- R9: `src_idx` equals instruction bits [15:8] combinationally. All other instruction bits outside 8..15 and 40..42 have no effect on the state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Apply the instruction at this edge |
| instr | input | 64 | Instruction word (fields at [15:8], 40, [42:41]) |
| src_val | input | 32 | Source register value |
| mask_val | input | 32 | Resolved per-target write mask |
| src_idx | output | 8 | Source register index for operand read |
| pred_q | output | 7 | Predicates, bit i is predicate i |
| flag_q | output | 4 | Flags ordered {O, C, S, Z} |

## Verification
The bench steps the lane selector through all four values in both modes. A design that ignored the selector, or scaled it by something other than eight, would write bits from the wrong lane. It also sends masks with every high bit set but the low target bits clear, and sources with bits set only outside the selected lane. A design that took its mask or source bits from the wrong range would change state here when nothing should change. Flag-mode updates are checked with distinct bit patterns, so a swapped Z/S/C/O order shows up as a wrong `flag_q`. Updates that leak into the unselected mode, or that take effect with `issue` low, show up as a change in state that should have held.

// File: rtl/rpmove_pkg.sv
package rpmove_pkg;
   typedef enum logic {
      TGT_PRED = 1'b0,
      TGT_FLAG = 1'b1
   } tgt_mode_e;

   localparam int DEF_INSN_W    = 64;
   localparam int DEF_SRC_W     = 32;
   localparam int DEF_LANE_W    = 8;
   localparam int DEF_NUM_PRED  = 7;
   localparam int DEF_NUM_FLAG  = 4;
   localparam int DEF_IDX_LO    = 8;
   localparam int DEF_IDX_W     = 8;
   localparam int DEF_MODE_POS  = 40;
   localparam int DEF_LSEL_LO   = 41;
endpackage

// File: rtl/rpmove_decode.sv
module rpmove_decode
   import rpmove_pkg::*;
#(
   parameter int INSN_W   = DEF_INSN_W,
   parameter int IDX_LO   = DEF_IDX_LO,
   parameter int IDX_W    = DEF_IDX_W,
   parameter int MODE_POS = DEF_MODE_POS,
   parameter int LSEL_LO  = DEF_LSEL_LO,
   parameter int LSEL_W   = 2
) (
   input  logic [INSN_W-1:0] instr,
   output logic [IDX_W-1:0]  idx,
   output tgt_mode_e         mode,
   output logic [LSEL_W-1:0] lsel
);
   generate
      if (IDX_LO + IDX_W > INSN_W) begin : g_bad_idx
         $error("register index field lies outside the instruction word");
      end
      if (LSEL_LO + LSEL_W > INSN_W) begin : g_bad_lsel
         $error("lane selector field lies outside the instruction word");
      end
      if (MODE_POS >= INSN_W) begin : g_bad_mode
         $error("mode bit lies outside the instruction word");
      end
   endgenerate

   always_comb begin
      idx  = instr[IDX_LO +: IDX_W];
      mode = tgt_mode_e'(instr[MODE_POS]);
      lsel = instr[LSEL_LO +: LSEL_W];
   end
endmodule

// File: rtl/rpmove_lane_sel.sv
module rpmove_lane_sel #(
   parameter int SRC_W  = 32,
   parameter int LANE_W = 8,
   localparam int NUM_LANES = SRC_W / LANE_W,
   localparam int LSEL_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
   input  logic [SRC_W-1:0]  src,
   input  logic [LSEL_W-1:0] lsel,
   output logic [LANE_W-1:0] lane
);
   logic [LANE_W-1:0] lanes [NUM_LANES];

   generate
      if (SRC_W % LANE_W != 0) begin : g_bad_split
         $error("source width must be a whole number of lanes");
      end
      for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
         assign lanes[g] = src[g*LANE_W +: LANE_W];
      end
      if ((1 << LSEL_W) == NUM_LANES) begin : g_full
         assign lane = lanes[lsel];
      end else begin : g_partial
         always_comb begin
            lane = '0;
            for (int k = 0; k < NUM_LANES; k++) begin
               if (lsel == LSEL_W'(k)) lane = lanes[k];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/rpmove_bank.sv
module rpmove_bank #(
   parameter int NBITS = 7
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [NBITS-1:0] wmask,
   input  logic [NBITS-1:0] din,
   output logic [NBITS-1:0] q
);
   generate
      if (NBITS < 1) begin : g_bad_n
         $error("bank needs at least one bit");
      end
      for (genvar g = 0; g < NBITS; g++) begin : g_bit
         always_ff @(posedge clk) begin
            if (rst)                      q[g] <= 1'b0;
            else if (wr_en && wmask[g])   q[g] <= din[g];
         end

         // R6: a masked-off bit holds across an issued update
         a_r6_mask_keep: assert property (@(posedge clk) disable iff (rst)
            (wr_en && !wmask[g]) |=> (q[g] == $past(q[g])));

         // R3: an enabled bit takes the selected data bit
         a_r3_bit_take: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wmask[g]) |=> (q[g] == $past(din[g])));
      end
   endgenerate

   // R2: no write enable, no change
   a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(q));

   // R1: reset leaves the bank cleared
   a_r1_reset_clear: assert property (@(posedge clk)
      rst |=> (q == '0));
endmodule

// File: rtl/rpmove_unit.sv
module rpmove_unit
   import rpmove_pkg::*;
#(
   parameter int INSN_W   = DEF_INSN_W,
   parameter int SRC_W    = DEF_SRC_W,
   parameter int LANE_W   = DEF_LANE_W,
   parameter int NUM_PRED = DEF_NUM_PRED,
   parameter int NUM_FLAG = DEF_NUM_FLAG,
   parameter int IDX_LO   = DEF_IDX_LO,
   parameter int IDX_W    = DEF_IDX_W,
   parameter int MODE_POS = DEF_MODE_POS,
   parameter int LSEL_LO  = DEF_LSEL_LO,
   localparam int NUM_LANES = SRC_W / LANE_W,
   localparam int LSEL_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                issue,
   input  logic [INSN_W-1:0]   instr,
   input  logic [SRC_W-1:0]    src_val,
   input  logic [SRC_W-1:0]    mask_val,
   output logic [IDX_W-1:0]    src_idx,
   output logic [NUM_PRED-1:0] pred_q,
   output logic [NUM_FLAG-1:0] flag_q
);
   generate
      if (NUM_PRED > LANE_W) begin : g_bad_pred
         $error("more predicates than bits in a lane");
      end
      if (NUM_FLAG > LANE_W) begin : g_bad_flag
         $error("more flags than bits in a lane");
      end
   endgenerate

   tgt_mode_e         mode;
   logic [LSEL_W-1:0] lsel;
   logic [LANE_W-1:0] lane;
   logic              pred_wr;
   logic              flag_wr;

   rpmove_decode #(
      .INSN_W  (INSN_W),
      .IDX_LO  (IDX_LO),
      .IDX_W   (IDX_W),
      .MODE_POS(MODE_POS),
      .LSEL_LO (LSEL_LO),
      .LSEL_W  (LSEL_W)
   ) u_dec (
      .instr(instr),
      .idx  (src_idx),
      .mode (mode),
      .lsel (lsel)
   );

   rpmove_lane_sel #(
      .SRC_W (SRC_W),
      .LANE_W(LANE_W)
   ) u_lane (
      .src (src_val),
      .lsel(lsel),
      .lane(lane)
   );

   assign pred_wr = issue && (mode == TGT_PRED);
   assign flag_wr = issue && (mode == TGT_FLAG);

   rpmove_bank #(.NBITS(NUM_PRED)) u_pred (
      .clk  (clk),
      .rst  (rst),
      .wr_en(pred_wr),
      .wmask(mask_val[NUM_PRED-1:0]),
      .din  (lane[NUM_PRED-1:0]),
      .q    (pred_q)
   );

   // flag index order: 0 = Z, 1 = S, 2 = C, 3 = O
   rpmove_bank #(.NBITS(NUM_FLAG)) u_flag (
      .clk  (clk),
      .rst  (rst),
      .wr_en(flag_wr),
      .wmask(mask_val[NUM_FLAG-1:0]),
      .din  (lane[NUM_FLAG-1:0]),
      .q    (flag_q)
   );

   // R8: a flag-mode issue leaves predicates untouched
   a_r8_pred_untouched: assert property (@(posedge clk) disable iff (rst)
      (issue && instr[MODE_POS]) |=> $stable(pred_q));

   // R8: a predicate-mode issue leaves flags untouched
   a_r8_flag_untouched: assert property (@(posedge clk) disable iff (rst)
      (issue && !instr[MODE_POS]) |=> $stable(flag_q));

   // R2: no issue, no state change anywhere
   a_r2_no_issue: assert property (@(posedge clk) disable iff (rst)
      !issue |=> ($stable(pred_q) && $stable(flag_q)));

   // R9: index output tracks the instruction field
   always_comb begin
      a_r9_idx_field: assert (src_idx == instr[IDX_LO +: IDX_W]);
   end
endmodule

// File: tb/sim_rpmove_unit.sv
`timescale 1ns/1ps
module sim_rpmove_unit;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        issue = 1'b0;
   logic [63:0] instr = '0;
   logic [31:0] src_val = '0;
   logic [31:0] mask_val = '0;
   logic [7:0]  src_idx;
   logic [6:0]  pred_q;
   logic [3:0]  flag_q;

   always #4 clk = ~clk;

   rpmove_unit u0 (
      .clk(clk), .rst(rst), .issue(issue), .instr(instr),
      .src_val(src_val), .mask_val(mask_val),
      .src_idx(src_idx), .pred_q(pred_q), .flag_q(flag_q)
   );

   typedef struct {
      logic [6:0] pred;
      logic [3:0] flag;
      string      tag;
   } exp_t;

   exp_t   sb [$];
   int     checks = 0;
   int     fails  = 0;
   logic [6:0] m_pred = '0;
   logic [3:0] m_flag = '0;
   bit     done = 0;

   function automatic logic [63:0] mk_insn(logic [7:0] idx, logic mode,
                                           logic [1:0] lsel, logic [63:0] junk);
      logic [63:0] w;
      w = junk;
      w[15:8]  = idx;
      w[40]    = mode;
      w[42:41] = lsel;
      return w;
   endfunction

   task automatic drive(input logic r, input logic iss, input logic [63:0] w,
                        input logic [31:0] s, input logic [31:0] m, input string tag);
      int off;
      @(negedge clk);
      rst = r; issue = iss; instr = w; src_val = s; mask_val = m;
      #1;
      checks++;
      if (src_idx !== w[15:8]) begin
         fails++;
         $display("FAIL R9 src_idx actual=%h expected=%h", src_idx, w[15:8]);
      end
      off = 8 * int'(w[42:41]);
      if (r) begin
         m_pred = '0; m_flag = '0;
      end else if (iss) begin
         if (!w[40]) begin
            for (int i = 0; i < 7; i++) if (m[i]) m_pred[i] = s[off+i];
         end else begin
            for (int i = 0; i < 4; i++) if (m[i]) m_flag[i] = s[off+i];
         end
      end
      @(posedge clk);
      #1;
      sb.push_back('{pred: m_pred, flag: m_flag, tag: tag});
   endtask

   // monitor
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         if (sb.size() > 0) begin
            e = sb.pop_front();
            checks++;
            if (pred_q !== e.pred || flag_q !== e.flag) begin
               fails++;
               $display("FAIL %s pred/flag actual=%b/%b expected=%b/%b",
                        e.tag, pred_q, flag_q, e.pred, e.flag);
            end
         end
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      drive(1, 0, '0, '0, '0, "R1 reset");
      drive(1, 1, mk_insn(8'h11, 0, 0, '0), 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1 reset wins");
      // R3 predicate mode, lane 0
      drive(0, 1, mk_insn(8'h05, 0, 0, '0), 32'h0000_005A, 32'hFFFF_FFFF, "R3 pred lane0");
      // R4 lane 3 reads [31:24]; expect P = 0x25
      drive(0, 1, mk_insn(8'h06, 0, 3, '0), 32'hA500_0000, 32'h0000_007F, "R4 pred lane3");
      drive(0, 1, mk_insn(8'h07, 0, 1, '0), 32'h0000_3300, 32'h0000_007F, "R4 pred lane1");
      drive(0, 1, mk_insn(8'h08, 0, 2, '0), 32'h004C_0000, 32'h0000_007F, "R4 pred lane2");
      // R5 flag mode, lane 1: Z=1 S=0 C=0 O=1 -> flag_q=1001
      drive(0, 1, mk_insn(8'h09, 1, 1, '0), 32'h0000_0900, 32'h0000_000F, "R5 flag order");
      drive(0, 1, mk_insn(8'h0A, 1, 3, '0), 32'h0600_0000, 32'h0000_000F, "R5 flag lane3");
      // R6 partial mask: only P1 and P4 written
      drive(0, 1, mk_insn(8'h0B, 0, 0, '0), 32'h0000_0012, 32'h0000_0012, "R6 partial mask set");
      drive(0, 1, mk_insn(8'h0C, 0, 0, '0), 32'h0000_0000, 32'h0000_0002, "R6 partial mask clear");
      drive(0, 1, mk_insn(8'h0D, 1, 0, '0), 32'h0000_0000, 32'h0000_0004, "R6 flag single");
      // R7 high mask bits ignored
      drive(0, 1, mk_insn(8'h0E, 0, 0, '0), 32'hFFFF_FF80, 32'hFFFF_FF80, "R7 pred high mask");
      drive(0, 1, mk_insn(8'h0F, 1, 2, '0), 32'hFFFF_FFFF, 32'hFFFF_FFF0, "R7 flag high mask");
      // R7 source outside lane ignored
      drive(0, 1, mk_insn(8'h10, 0, 2, '0), 32'hFF80_FFFF, 32'h0000_007F, "R7 pred outside lane");
      // R2 issue low
      drive(0, 0, mk_insn(8'h12, 0, 0, '0), 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 no issue pred");
      drive(0, 0, mk_insn(8'h13, 1, 0, '0), 32'h0000_0000, 32'hFFFF_FFFF, "R2 no issue flag");
      // R8 cross-mode isolation
      drive(0, 1, mk_insn(8'h14, 1, 0, '0), 32'h0000_000F, 32'hFFFF_FFFF, "R8 flag leaves pred");
      drive(0, 1, mk_insn(8'h15, 0, 0, '0), 32'h0000_0000, 32'hFFFF_FFFF, "R8 pred leaves flag");
      // R9 junk in unused instruction bits
      drive(0, 1, mk_insn(8'hA7, 0, 1, 64'hFFFF_F8FF_FFFF_00FF), 32'h0000_7F00, 32'h0000_007F,
            "R9 junk bits");
      for (int n = 0; n < 300; n++) begin
         drive(($urandom % 40) == 0, ($urandom % 4) != 0,
               mk_insn(8'($urandom), 1'($urandom), 2'($urandom), {$urandom, $urandom}),
               $urandom, $urandom, "R3 R5 random");
      end
      drive(1, 0, '0, '0, '0, "R1 final reset");
      @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule